// File: doc/BRIEF.md
# USB Host Port Wake-Event Register

This block is one port's wake-control slice of a USB host controller. It holds a 32-bit port register with three wake-enable fields: wake on connect, wake on disconnect and wake on over-current. The same register shows the port's current connect state and its over-current state. Both are brought in from the port as raw levels and passed through a synchronizer first. When an enabled wake condition occurs, the block sets a sticky power-management event flag. That flag is bit 15 of a separate power-management status register, and software clears it with its own write.

The two connect directions are detected on the synchronized connect level, one pulse per transition. Connect and disconnect each have their own enable. The over-current wake follows the synchronized over-current level: the flag is set on every cycle that the level and its enable are both high. Software writes the register in one cycle through a plain strobe-and-data port and reads it back combinationally.

Top module: `usb_port_wake`

## Requirements
- R1: After reset the register reads 0x00003000 and the event flag is 0, provided both port inputs are low.
- R2: Bits 13 and 12 always read 1. Bits 31:23, 19:14, 11:5 and 3:1 always read 0. Writes to any of these bits have no effect.
- R3: Bit 22 (over-current wake enable), bit 21 (disconnect wake enable) and bit 20 (connect wake enable) are read/write. A write takes effect on the next clock edge.
- R4: Bit 0 shows the connect input and bit 4 shows the over-current input, each delayed by SYNC_STAGES clock edges. Register writes to bits 0 and 4 have no effect.
- R5: When bit 20 is 1 and bit 0 changes from 0 to 1, the event flag is 1 on the clock edge after bit 0 changes.
- R6: When bit 21 is 1 and bit 0 changes from 1 to 0, the event flag is 1 on the clock edge after bit 0 changes.
- R7: When bit 22 is 1 and bit 4 is 1, the event flag is 1 on the next clock edge.
- R8: A connect transition whose own enable is 0 never sets the flag, even if the enable for the opposite direction is 1. Over-current never sets the flag while bit 22 is 0.
- R9: The event flag is sticky. Only a power-management write with the bit-15 value of 1 clears it. A power-management write with that value at 0 leaves the flag unchanged.
- R10: When a wake event and a clearing write happen in the same cycle, the flag ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Port register write strobe |
| reg_wr_data | input | 32 | Port register write data |
| reg_rd_data | output | 32 | Port register read data |
| port_connect_raw | input | 1 | Unsynchronized connect level from the port |
| port_ovc_raw | input | 1 | Unsynchronized over-current level from the port |
| pm_wr_en | input | 1 | Power-management status register write strobe |
| pm_wr_pme | input | 1 | Value written to bit 15 of the power-management status register (1 clears the flag) |
| pme_status | output | 1 | Sticky wake event flag (bit 15 of the power-management status register) |

## Verification
The hardest case to reach from the ports is a single-cycle connect-edge pulse that lands in the same cycle as a clearing write. The edge pulse exists for only one cycle, and it comes after the synchronizer delay. To hit it, the bench first clears the flag. It then raises the connect input on a falling clock edge and counts the synchronizer stages plus the edge register. It asserts the clearing write for exactly the cycle in which the pulse is live. The over-current path gives a second way to collide: its level is held high while the clear is written.

// File: rtl/usb_wake_pkg.sv
package usb_wake_pkg;

  localparam int unsigned REG_W       = 32;
  localparam int unsigned CCS_BIT     = 0;
  localparam int unsigned OCA_BIT     = 4;
  localparam int unsigned HI0_BIT     = 12;
  localparam int unsigned HI1_BIT     = 13;
  localparam int unsigned WK_CON_BIT  = 20;
  localparam int unsigned WK_DIS_BIT  = 21;
  localparam int unsigned WK_OC_BIT   = 22;

  localparam logic [REG_W-1:0] FIXED_ONES =
    (REG_W'(1) << HI0_BIT) | (REG_W'(1) << HI1_BIT);

  localparam logic [REG_W-1:0] LIVE_MASK =
    FIXED_ONES | (REG_W'(1) << CCS_BIT) | (REG_W'(1) << OCA_BIT) |
    (REG_W'(1) << WK_CON_BIT) | (REG_W'(1) << WK_DIS_BIT) |
    (REG_W'(1) << WK_OC_BIT);

  localparam logic [REG_W-1:0] RESET_VALUE = FIXED_ONES;

  typedef struct packed {
    logic on_oc;
    logic on_dis;
    logic on_con;
  } wake_en_t;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned W      = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_raw,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        assign stg_d[s] = d_raw;
      end else begin : g_next
        assign stg_d[s] = stg_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          stg_q[s] <= '0;
        end else begin
          stg_q[s] <= stg_d[s];
        end
      end
    end
  endgenerate

  assign q_sync = stg_q[STAGES-1];

endmodule

// File: rtl/wake_edge.sv
module wake_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  output logic rise,
  output logic fall
);

  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= level;
    end
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;

endmodule

// File: rtl/wake_enable_reg.sv
module wake_enable_reg
  import usb_wake_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_en,
  input  wake_en_t wr_field,
  output wake_en_t en_q
);

  wake_en_t en_d;

  always_comb begin
    en_d = en_q;
    if (wr_en) begin
      en_d = wr_field;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/wake_pme_flag.sv
module wake_pme_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag_q
);

  logic flag_d;

  always_comb begin
    flag_d = flag_q;
    if (set_evt) begin
      flag_d = 1'b1;
    end else if (clr_req) begin
      flag_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

endmodule

// File: rtl/usb_port_wake.sv
module usb_port_wake
  import usb_wake_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr_en,
  input  logic [REG_W-1:0] reg_wr_data,
  output logic [REG_W-1:0] reg_rd_data,
  input  logic             port_connect_raw,
  input  logic             port_ovc_raw,
  input  logic             pm_wr_en,
  input  logic             pm_wr_pme,
  output logic             pme_status
);

  logic [1:0] raw_lvl;
  logic [1:0] sync_lvl;
  logic       conn_s;
  logic       ovc_s;
  logic       conn_rise;
  logic       conn_fall;
  wake_en_t   wr_field;
  wake_en_t   en_q;
  logic       wake_evt;
  logic       unused_wr_bits;

  assign raw_lvl = {port_ovc_raw, port_connect_raw};

  wake_sync #(
    .STAGES (SYNC_STAGES),
    .W      (2)
  ) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_raw  (raw_lvl),
    .q_sync (sync_lvl)
  );

  assign conn_s = sync_lvl[0];
  assign ovc_s  = sync_lvl[1];

  wake_edge u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .level (conn_s),
    .rise  (conn_rise),
    .fall  (conn_fall)
  );

  assign wr_field.on_oc  = reg_wr_data[WK_OC_BIT];
  assign wr_field.on_dis = reg_wr_data[WK_DIS_BIT];
  assign wr_field.on_con = reg_wr_data[WK_CON_BIT];

  assign unused_wr_bits = ^(reg_wr_data & ~LIVE_MASK) ^ reg_wr_data[CCS_BIT] ^
                          reg_wr_data[OCA_BIT] ^ reg_wr_data[HI0_BIT] ^
                          reg_wr_data[HI1_BIT];

  wake_enable_reg u_en (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr_en),
    .wr_field (wr_field),
    .en_q     (en_q)
  );

  assign wake_evt = (en_q.on_con & conn_rise) |
                    (en_q.on_dis & conn_fall) |
                    (en_q.on_oc  & ovc_s);

  wake_pme_flag u_pme (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (wake_evt),
    .clr_req (pm_wr_en & pm_wr_pme),
    .flag_q  (pme_status)
  );

  always_comb begin
    reg_rd_data             = FIXED_ONES;
    reg_rd_data[CCS_BIT]    = conn_s;
    reg_rd_data[OCA_BIT]    = ovc_s;
    reg_rd_data[WK_CON_BIT] = en_q.on_con;
    reg_rd_data[WK_DIS_BIT] = en_q.on_dis;
    reg_rd_data[WK_OC_BIT]  = en_q.on_oc;
  end

endmodule

// File: rtl/usb_port_wake_chk.sv
module usb_port_wake_chk
  import usb_wake_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [REG_W-1:0] reg_rd_data,
  input logic             pm_wr_en,
  input logic             pm_wr_pme,
  input logic             pme_status
);

  a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data & ~LIVE_MASK) == '0 && (reg_rd_data & FIXED_ONES) == FIXED_ONES);

  a_r5_connect_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[WK_CON_BIT] && $rose(reg_rd_data[CCS_BIT])) |=> pme_status);

  a_r6_disconnect_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[WK_DIS_BIT] && $fell(reg_rd_data[CCS_BIT])) |=> pme_status);

  a_r7_overcurrent_wake: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd_data[WK_OC_BIT] && reg_rd_data[OCA_BIT]) |=> pme_status);

  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (pme_status && !(pm_wr_en && pm_wr_pme)) |=> pme_status);

  a_r10_clear_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pme_status) |-> $past(pm_wr_en && pm_wr_pme));

endmodule

bind usb_port_wake usb_port_wake_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_rd_data (reg_rd_data),
  .pm_wr_en    (pm_wr_en),
  .pm_wr_pme   (pm_wr_pme),
  .pme_status  (pme_status)
);

// File: tb/usb_port_wake_tb.sv
module usb_port_wake_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] BASE = 32'h0000_3000;

  logic        clk;
  logic        rst_n;
  logic        reg_wr_en;
  logic [31:0] reg_wr_data;
  logic [31:0] reg_rd_data;
  logic        port_connect_raw;
  logic        port_ovc_raw;
  logic        pm_wr_en;
  logic        pm_wr_pme;
  logic        pme_status;

  int checks;
  int failures;

  usb_port_wake u_dut (
    .clk              (clk),
    .rst_n            (rst_n),
    .reg_wr_en        (reg_wr_en),
    .reg_wr_data      (reg_wr_data),
    .reg_rd_data      (reg_rd_data),
    .port_connect_raw (port_connect_raw),
    .port_ovc_raw     (port_ovc_raw),
    .pm_wr_en         (pm_wr_en),
    .pm_wr_pme        (pm_wr_pme),
    .pme_status       (pme_status)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_write(input logic [31:0] v);
    @(negedge clk);
    reg_wr_en   = 1'b1;
    reg_wr_data = v;
    @(negedge clk);
    reg_wr_en   = 1'b0;
    reg_wr_data = '0;
  endtask

  task automatic pm_write(input logic v);
    @(negedge clk);
    pm_wr_en  = 1'b1;
    pm_wr_pme = v;
    @(negedge clk);
    pm_wr_en  = 1'b0;
    pm_wr_pme = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    reg_wr_en = 1'b0; reg_wr_data = '0;
    port_connect_raw = 1'b0; port_ovc_raw = 1'b0;
    pm_wr_en = 1'b0; pm_wr_pme = 1'b0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    chk("R1", "reset register", reg_rd_data, BASE);
    chk("R1", "reset flag", {31'd0, pme_status}, 32'd0);
  endtask

  task automatic t_fields;
    reg_write(32'hFFFF_FFFF);
    chk("R3", "all-ones write", reg_rd_data, BASE | 32'h0070_0000);
    chk("R2", "fixed bits after all-ones", reg_rd_data & ~32'h0070_0000, BASE);
    reg_write(32'h0000_0000);
    chk("R2", "zero write keeps fixed ones", reg_rd_data, BASE);
    reg_write(32'h0020_0011);
    chk("R4", "write to bits 0/4 ignored", reg_rd_data, BASE | 32'h0020_0000);
    reg_write(32'h0);
    chk("R3", "no flag from writes", {31'd0, pme_status}, 32'd0);
  endtask

  task automatic t_mirror;
    @(negedge clk);
    port_connect_raw = 1'b1;
    @(negedge clk);
    chk("R4", "connect not yet visible", {31'd0, reg_rd_data[0]}, 32'd0);
    @(negedge clk);
    chk("R4", "connect visible after sync", {31'd0, reg_rd_data[0]}, 32'd1);
    port_connect_raw = 1'b0;
    port_ovc_raw = 1'b1;
    wait_n(3);
    chk("R4", "over-current visible", reg_rd_data, BASE | 32'h10);
    port_ovc_raw = 1'b0;
    wait_n(3);
    chk("R8", "no flag with enables clear", {31'd0, pme_status}, 32'd0);
  endtask

  task automatic t_connect_wake;
    reg_write(32'h0010_0000);
    @(negedge clk);
    port_connect_raw = 1'b1;
    wait_n(2);
    chk("R5", "bit0 set, flag not yet", {30'd0, pme_status, reg_rd_data[0]}, 32'd1);
    wait_n(1);
    chk("R5", "flag after connect edge", {31'd0, pme_status}, 32'd1);
    wait_n(10);
    chk("R9", "flag sticky", {31'd0, pme_status}, 32'd1);
    pm_write(1'b0);
    chk("R9", "write of 0 keeps flag", {31'd0, pme_status}, 32'd1);
    pm_write(1'b1);
    chk("R9", "write of 1 clears flag", {31'd0, pme_status}, 32'd0);
    port_connect_raw = 1'b0;
    wait_n(5);
    chk("R8", "disconnect with only connect enable", {31'd0, pme_status}, 32'd0);
  endtask

  task automatic t_disconnect_wake;
    reg_write(32'h0020_0000);
    port_connect_raw = 1'b1;
    wait_n(5);
    chk("R8", "connect with only disconnect enable", {31'd0, pme_status}, 32'd0);
    port_connect_raw = 1'b0;
    wait_n(5);
    chk("R6", "flag after disconnect", {31'd0, pme_status}, 32'd1);
    pm_write(1'b1);
    chk("R9", "clear after disconnect", {31'd0, pme_status}, 32'd0);
  endtask

  task automatic t_overcurrent;
    reg_write(32'h0030_0000);
    port_ovc_raw = 1'b1;
    wait_n(5);
    chk("R8", "over-current ignored without its enable", {31'd0, pme_status}, 32'd0);
    reg_write(32'h0040_0000);
    wait_n(1);
    chk("R7", "flag from over-current", {31'd0, pme_status}, 32'd1);
    pm_write(1'b1);
    chk("R10", "level event beats clear", {31'd0, pme_status}, 32'd1);
    port_ovc_raw = 1'b0;
    wait_n(4);
    pm_write(1'b1);
    chk("R9", "clear once level gone", {31'd0, pme_status}, 32'd0);
  endtask

  task automatic t_edge_collision;
    reg_write(32'h0010_0000);
    @(negedge clk);
    port_connect_raw = 1'b1;
    wait_n(2);
    pm_wr_en  = 1'b1;
    pm_wr_pme = 1'b1;
    @(negedge clk);
    pm_wr_en  = 1'b0;
    pm_wr_pme = 1'b0;
    chk("R10", "connect edge beats clear", {31'd0, pme_status}, 32'd1);
    pm_write(1'b1);
    chk("R9", "later clear works", {31'd0, pme_status}, 32'd0);
  endtask

  initial begin
    checks = 0;
    failures = 0;
    t_reset();
    t_fields();
    t_mirror();
    t_connect_wake();
    t_disconnect_wake();
    t_overcurrent();
    t_edge_collision();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule